// File: doc/BRIEF.md
# Pixel-to-Lane 7:1 Serializer

This block turns one parallel pixel per pixel period into seven serial bit slots on each of four data lanes, together with a lane clock that repeats every seven slots. It runs from a clock at the slot rate. A pixel strobe marks the cycle in which a new pixel word is presented. On the edge that samples the strobe, the block captures the pixel: 8-bit red, green and blue components plus four control bits (horizontal sync, vertical sync, data enable and a spare bit). It captures the mapping mode on the same edge.

Three bit mappings are available: an 18-bit mapping on three lanes, and two 24-bit mappings on four lanes. The two 24-bit mappings differ in where the two extra bits of each colour go. In the first, the fourth lane carries the two least significant bits of each colour. In the second, the fourth lane carries the two most significant bits, and the first three lanes carry the low six bits. The block keeps its own slot count. When a strobe arrives at the wrong slot, the block realigns to the new pixel and raises a sticky flag.

Top module: `lvds_px_serializer`

## Requirements
- R1: The edge that samples `px_strobe` high starts a pixel. Slot 0 appears on the outputs in the following cycle, and slots 1 to 6 follow in consecutive cycles, one slot per clock.
- R2: `lane_clk` is 1 during slots 5, 6, 0 and 1 and 0 during slots 2, 3 and 4.
- R3: With `map_mode` 0 (and the reserved code 3), lanes use the top six bits of each colour (c5 = input bit 7 down to c0 = input bit 2). The slot orders for slots 0 to 6 are: lane 0 = g0, r5, r4, r3, r2, r1, r0. Lane 1 = b1, b0, g5, g4, g3, g2, g1. Lane 2 = ctl[2], ctl[1], ctl[0], b5, b4, b3, b2. Lane 3 stays 0.
- R4: With `map_mode` 1, lanes 0 to 2 carry the same slot orders as R3, with the same top-six-bit selection. For slots 0 to 6, lane 3 carries ctl[3], blue[1], blue[0], green[1], green[0], red[1], red[0].
- R5: With `map_mode` 2, lanes 0 to 2 follow the slot orders of R3 but use the low six bits (c5 = input bit 5). For slots 0 to 6, lane 3 carries ctl[3], blue[7], blue[6], green[7], green[6], red[7], red[6].
- R6: Pixel inputs and `map_mode` are sampled only on a strobe edge. Changing them between strobes has no effect on the pixel being sent.
- R7: Without a strobe, the slot count wraps from 6 to 0 and the held pixel is sent again with the same mapping.
- R8: Once a pixel has been loaded since reset, a strobe that arrives when the current slot is not 6 restarts the outputs at slot 0 of the new pixel and sets `misalign` to 1. `misalign` stays 1 until reset. The first strobe after reset never sets it.
- R9: Synchronous reset drives all lanes to 0, sets `lane_clk` to 1 (slot 0), clears `misalign` and the held pixel, and restarts the slot count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| px_strobe | input | 1 | Marks the cycle that presents a new pixel |
| map_mode | input | 2 | 0: 18-bit, 1: 24-bit low-bits-on-lane-3, 2: 24-bit high-bits-on-lane-3, 3: as 0 |
| red | input | 8 | Red component |
| green | input | 8 | Green component |
| blue | input | 8 | Blue component |
| ctl | input | 4 | Control bits: [0] hsync, [1] vsync, [2] data enable, [3] spare |
| lane_data | output | 4 | Serial data, one bit per lane |
| lane_clk | output | 1 | Lane clock pattern |
| misalign | output | 1 | Sticky flag for a strobe at the wrong slot |

## Verification
The hardest case to reach from the ports is a strobe that arrives in the middle of a pixel after a pixel has already been loaded. The bench keeps its own slot count, derived only from reset and the strobes it drives. It waits until its expected-output queue has drained, then fires a strobe at slot 3. It then expects slot 0 of the new pixel at once and the flag to stay set through later aligned pixels. After every strobe, the bench also scrambles the mode and colour inputs, so any late sampling would corrupt the queued slot values.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;

    localparam int SLOTS     = 7;
    localparam int LANES     = 4;
    localparam int COMP_W    = 8;
    localparam int CORE_W    = 6;
    localparam int EXT_W     = COMP_W - CORE_W;
    localparam int CTL_W     = 4;
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int CLK_FALL  = 2;
    localparam int CLK_RISE  = 5;

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    typedef enum logic [1:0] {
        MAP_NARROW  = 2'd0,
        MAP_WIDE_LO = 2'd1,
        MAP_WIDE_HI = 2'd2,
        MAP_RSVD    = 2'd3
    } map_mode_e;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
        logic [CTL_W-1:0]  ctl;
    } pixel_t;

    typedef logic [SLOTS-1:0] slot_word_t;

    function automatic logic clk_level(input logic [SLOT_W-1:0] s);
        return (int'(s) < CLK_FALL) || (int'(s) >= CLK_RISE);
    endfunction

    function automatic logic uses_fourth_lane(input map_mode_e m);
        return (m == MAP_WIDE_LO) || (m == MAP_WIDE_HI);
    endfunction

    // Low six bits in the high-on-lane-3 mapping, top six otherwise.
    function automatic logic [CORE_W-1:0] core_bits(input map_mode_e m, input logic [COMP_W-1:0] c);
        return (m == MAP_WIDE_HI) ? c[CORE_W-1:0] : c[COMP_W-1:EXT_W];
    endfunction

    function automatic logic [EXT_W-1:0] ext_bits(input map_mode_e m, input logic [COMP_W-1:0] c);
        return (m == MAP_WIDE_HI) ? c[COMP_W-1:CORE_W] : c[EXT_W-1:0];
    endfunction

    // Word for one lane; bit k is the value sent in slot k.
    function automatic slot_word_t lane_word(input map_mode_e m, input pixel_t p, input int lane);
        slot_word_t        w;
        logic [CORE_W-1:0] r6, g6, b6;
        logic [EXT_W-1:0]  r2, g2, b2;
        r6 = core_bits(m, p.r);
        g6 = core_bits(m, p.g);
        b6 = core_bits(m, p.b);
        r2 = ext_bits(m, p.r);
        g2 = ext_bits(m, p.g);
        b2 = ext_bits(m, p.b);
        w  = '0;
        case (lane)
            0: begin
                w[0] = g6[0];
                for (int k = 1; k < SLOTS; k++) w[k] = r6[SLOTS-1-k];
            end
            1: begin
                w[0] = b6[1];
                w[1] = b6[0];
                for (int k = 2; k < SLOTS; k++) w[k] = g6[SLOTS-k];
            end
            2: begin
                for (int k = 0; k < 3; k++) w[k] = p.ctl[2-k];
                for (int k = 3; k < SLOTS; k++) w[k] = b6[SLOTS+1-k];
            end
            default: begin
                if (uses_fourth_lane(m))
                    w = {r2[0], r2[1], g2[0], g2[1], b2[0], b2[1], p.ctl[3]};
            end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/lvds_slot_timer.sv
module lvds_slot_timer
    import lvds_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              px_strobe,
    output logic              load,
    output logic [SLOT_W-1:0] slot_nxt,
    output logic [SLOT_W-1:0] slot_q,
    output logic              lane_clk,
    output logic              misalign
);

    logic armed_q;

    assign load = px_strobe;

    always_comb begin
        if (px_strobe || slot_q == LAST_SLOT)
            slot_nxt = '0;
        else
            slot_nxt = slot_q + SLOT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= '0;
            lane_clk <= 1'b1;
            armed_q  <= 1'b0;
            misalign <= 1'b0;
        end else begin
            slot_q   <= slot_nxt;
            lane_clk <= clk_level(slot_nxt);
            if (px_strobe) armed_q <= 1'b1;
            if (px_strobe && armed_q && slot_q != LAST_SLOT) misalign <= 1'b1;
        end
    end

    assert_reset_state_R9: assert property (@(posedge clk)
        rst |=> (slot_q == '0 && lane_clk && !misalign));

    assert_strobe_slot0_R1: assert property (@(posedge clk) disable iff (rst)
        px_strobe |=> (slot_q == '0 && lane_clk));

    assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (!px_strobe && slot_q == LAST_SLOT) |=> slot_q == '0);

    assert_clk_fall_R2: assert property (@(posedge clk) disable iff (rst)
        (!px_strobe && slot_q == SLOT_W'(CLK_FALL - 1)) |=> !lane_clk);

    assert_clk_rise_R2: assert property (@(posedge clk) disable iff (rst)
        (!px_strobe && slot_q == SLOT_W'(CLK_RISE - 1)) |=> lane_clk);

    assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (rst)
        misalign |=> misalign);

endmodule

// File: rtl/lvds_lane_mapper.sv
module lvds_lane_mapper
    import lvds_ser_pkg::*;
(
    input  map_mode_e  mode,
    input  pixel_t     pix,
    output slot_word_t words [LANES]
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign words[i] = lane_word(mode, pix, i);
    end

endmodule

// File: rtl/lvds_lane_shifter.sv
module lvds_lane_shifter
    import lvds_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  slot_word_t        new_word,
    input  logic [SLOT_W-1:0] slot_nxt,
    output logic              dout
);

    slot_word_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            dout   <= 1'b0;
        end else if (load) begin
            held_q <= new_word;
            dout   <= new_word[slot_nxt];
        end else begin
            dout   <= held_q[slot_nxt];
        end
    end

    assert_lane_reset_R9: assert property (@(posedge clk)
        rst |=> !dout);

    assert_load_first_slot_R1: assert property (@(posedge clk) disable iff (rst)
        load |=> dout == $past(new_word[0]));

endmodule

// File: rtl/lvds_px_serializer.sv
module lvds_px_serializer
    import lvds_ser_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       px_strobe,
    input  logic [1:0] map_mode,
    input  logic [7:0] red,
    input  logic [7:0] green,
    input  logic [7:0] blue,
    input  logic [3:0] ctl,
    output logic [3:0] lane_data,
    output logic       lane_clk,
    output logic       misalign
);

    logic              load;
    logic [SLOT_W-1:0] slot_nxt;
    logic [SLOT_W-1:0] slot_q;
    pixel_t            pix_in;
    slot_word_t        words [LANES];
    map_mode_e         mode_q;

    assign pix_in = '{r: red, g: green, b: blue, ctl: ctl};

    lvds_slot_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .px_strobe(px_strobe),
        .load     (load),
        .slot_nxt (slot_nxt),
        .slot_q   (slot_q),
        .lane_clk (lane_clk),
        .misalign (misalign)
    );

    lvds_lane_mapper u_map (
        .mode (map_mode_e'(map_mode)),
        .pix  (pix_in),
        .words(words)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_shift
        lvds_lane_shifter u_shift (
            .clk     (clk),
            .rst     (rst),
            .load    (load),
            .new_word(words[i]),
            .slot_nxt(slot_nxt),
            .dout    (lane_data[i])
        );
    end

    // Mode seen by the pixel on the wire; kept for the lane-3 idle check.
    always_ff @(posedge clk) begin
        if (rst)       mode_q <= MAP_NARROW;
        else if (load) mode_q <= map_mode_e'(map_mode);
    end

    assert_narrow_lane3_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !uses_fourth_lane(mode_q) |-> !lane_data[LANES-1]);

    assert_slot_range_R7: assert property (@(posedge clk) disable iff (rst)
        slot_q <= LAST_SLOT);

endmodule

// File: tb/sim_lvds_px_serializer.sv
`timescale 1ns/1ps
module sim_lvds_px_serializer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       px_strobe = 1'b0;
    logic [1:0] map_mode = 2'd0;
    logic [7:0] red = '0, green = '0, blue = '0;
    logic [3:0] ctl = '0;
    logic [3:0] lane_data;
    logic       lane_clk;
    logic       misalign;

    lvds_px_serializer u0 (
        .clk(clk), .rst(rst), .px_strobe(px_strobe), .map_mode(map_mode),
        .red(red), .green(green), .blue(blue), .ctl(ctl),
        .lane_data(lane_data), .lane_clk(lane_clk), .misalign(misalign)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    int bslot = 0;
    bit armed_b = 1'b0;
    logic [4:0] exp_q [$];
    string      tag_q [$];
    logic [1:0] last_m;
    logic [7:0] last_r, last_g, last_b;
    logic [3:0] last_c;

    // Bench slot model, built from its own reset and strobe stimulus.
    always @(posedge clk) begin
        if (rst) begin
            bslot   <= 0;
            armed_b <= 1'b0;
        end else if (px_strobe) begin
            bslot   <= 0;
            armed_b <= 1'b1;
        end else begin
            bslot <= (bslot == 6) ? 0 : bslot + 1;
        end
    end

    function automatic logic exp_clk(int s);
        return (s == 0) || (s == 1) || (s == 5) || (s == 6);
    endfunction

    // Slot sequences written MSB = slot 0.
    function automatic logic [3:0] exp_lanes(logic [1:0] m, logic [7:0] r, logic [7:0] g,
                                             logic [7:0] b, logic [3:0] c, int s);
        logic [6:0] l0, l1, l2, l3;
        if (m == 2'd2) begin
            l0 = {g[0], r[5], r[4], r[3], r[2], r[1], r[0]};
            l1 = {b[1], b[0], g[5], g[4], g[3], g[2], g[1]};
            l2 = {c[2], c[1], c[0], b[5], b[4], b[3], b[2]};
            l3 = {c[3], b[7], b[6], g[7], g[6], r[7], r[6]};
        end else begin
            l0 = {g[2], r[7], r[6], r[5], r[4], r[3], r[2]};
            l1 = {b[3], b[2], g[7], g[6], g[5], g[4], g[3]};
            l2 = {c[2], c[1], c[0], b[7], b[6], b[5], b[4]};
            l3 = (m == 2'd1) ? {c[3], b[1], b[0], g[1], g[0], r[1], r[0]} : 7'd0;
        end
        return {l3[6-s], l2[6-s], l1[6-s], l0[6-s]};
    endfunction

    // Scoreboard monitor: one expected slot per cycle, sampled after the edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [4:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if ({lane_clk, lane_data} !== e) begin
                bad++;
                $display("FAIL %s (R2 clk): got clk=%b data=%b expected clk=%b data=%b",
                         t, lane_clk, lane_data, e[4], e[3:0]);
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic push_last(string tag);
        for (int s = 0; s < 7; s++) begin
            exp_q.push_back({exp_clk(s), exp_lanes(last_m, last_r, last_g, last_b, last_c, s)});
            tag_q.push_back(tag);
        end
    endtask

    // Drive one strobe at the current negedge, then scramble all inputs (R6).
    task automatic drive_px(logic [1:0] m, logic [7:0] r, logic [7:0] g, logic [7:0] b,
                            logic [3:0] c, string tag);
        map_mode = m; red = r; green = g; blue = b; ctl = c; px_strobe = 1'b1;
        last_m = m; last_r = r; last_g = g; last_b = b; last_c = c;
        push_last(tag);
        @(negedge clk);
        px_strobe = 1'b0;
        map_mode = m ^ 2'd3; red = ~r; green = g ^ 8'h5a; blue = ~b; ctl = ~c;
    endtask

    task automatic send_px(logic [1:0] m, logic [7:0] r, logic [7:0] g, logic [7:0] b,
                           logic [3:0] c, string tag);
        while (armed_b && bslot != 6) @(negedge clk);
        drive_px(m, r, g, b, c, tag);
    endtask

    task automatic idle_px(string tag);
        while (bslot != 6) @(negedge clk);
        push_last(tag);
        @(negedge clk);
    endtask

    task automatic misalign_px(int k, logic [1:0] m, logic [7:0] r, logic [7:0] g,
                               logic [7:0] b, logic [3:0] c, string tag);
        while (exp_q.size() > 0) @(negedge clk);
        while (bslot != k) @(negedge clk);
        drive_px(m, r, g, b, c, tag);
    endtask

    task automatic do_reset();
        while (exp_q.size() > 0) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(lane_data == 4'd0, "R9 lanes low", int'(lane_data), 0);
        chk(lane_clk == 1'b1, "R9 lane clock high", int'(lane_clk), 1);
        chk(misalign == 1'b0, "R9 flag cleared", int'(misalign), 0);
        rst = 1'b0;
        for (int i = 1; i <= 7; i++) begin
            exp_q.push_back({exp_clk(i % 7), 4'd0});
            tag_q.push_back("R9 held pixel zero");
        end
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        send_px(2'd0, 8'hA5, 8'h3C, 8'hF0, 4'b0101, "R3 first pixel");
        chk(misalign == 1'b0, "R8 first strobe not flagged", int'(misalign), 0);
        send_px(2'd1, 8'h81, 8'h42, 8'h24, 4'b1010, "R4 edges");
        send_px(2'd2, 8'hC3, 8'h18, 8'h7E, 4'b1001, "R5 mixed");
        send_px(2'd3, 8'hFF, 8'h00, 8'hFF, 4'b0111, "R3 reserved code");
        for (int i = 0; i < 8; i++) begin
            send_px(2'd0, 8'(1 << i), 8'(1 << ((i + 3) % 8)), 8'(1 << ((i + 5) % 8)),
                    4'(1 << (i % 4)), "R3 walking");
            send_px(2'd1, 8'(1 << i), 8'(1 << ((i + 2) % 8)), 8'(1 << ((i + 6) % 8)),
                    4'(1 << (i % 4)), "R4 walking");
            send_px(2'd2, 8'(1 << i), 8'(1 << ((i + 1) % 8)), 8'(1 << ((i + 4) % 8)),
                    4'(1 << (i % 4)), "R5 walking");
        end
        for (int i = 0; i < 12; i++)
            send_px(2'(i % 3), 8'($urandom), 8'($urandom), 8'($urandom), 4'($urandom),
                    "R6 inputs scrambled after capture");

        idle_px("R7 repeat without strobe");
        idle_px("R7 second repeat");
        send_px(2'd1, 8'h5A, 8'hA5, 8'h33, 4'b1100, "R1 after idle");
        chk(misalign == 1'b0, "R8 aligned strobes leave flag clear", int'(misalign), 0);

        misalign_px(3, 2'd2, 8'h96, 8'h69, 8'hC5, 4'b0110, "R8 realign at slot 3");
        chk(misalign == 1'b1, "R8 flag set", int'(misalign), 1);
        send_px(2'd0, 8'h12, 8'h34, 8'h56, 4'b0011, "R1 after realign");
        send_px(2'd1, 8'h9A, 8'hBC, 8'hDE, 4'b1111, "R4 after realign");
        while (exp_q.size() > 0) @(negedge clk);
        chk(misalign == 1'b1, "R8 flag sticky", int'(misalign), 1);

        do_reset();
        send_px(2'd2, 8'hE7, 8'h7E, 8'h18, 4'b1000, "R5 after reset");
        chk(misalign == 1'b0, "R8 first strobe after reset", int'(misalign), 0);
        while (exp_q.size() > 0) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule